// File: doc/BRIEF.md
# Multi-Mode Operand Fetch Unit

This unit turns an operand specifier into an operand value. A request carries an operation kind, a 3-bit addressing-mode code, a 32-bit constant field, and two register values (a base register `regM` and an index register `regN`). The unit then forms a byte effective address with modulo-2^32 arithmetic. It drives a single-ported synchronous memory with a ready handshake and returns the fetched value together with a one-cycle `done` pulse. In the memory-indirect mode the word found at the constant address is used as a pointer, and a second memory reference follows.

The same engine also serves stack traffic. A push moves the stack pointer down by one word and writes there. A pop reads at the stack pointer and then moves it up by one word. In both cases the new pointer value is presented on `spOut` with a write strobe, so the surrounding register file can update it. Requests are taken only while `reqReady` is high. The caller holds the request fields stable in the cycle it raises `reqValid`.

Top module: `operand_fetch_unit`

## Requirements
- R1: With `opKind`=0 (fetch) and `addrMode`=0, `operand` equals `constField` when `done` pulses, and no memory access is made.
- R2: With `addrMode`=1, exactly one read is made at `constField`, and `operand` is the word returned.
- R3: With `addrMode`=2, a read at `constField` is followed by a second read at the returned word, and `operand` is the second word returned (two accesses in total).
- R4: With `addrMode`=3, exactly one read is made at `regN`.
- R5: Modes 4, 5 and 6 make exactly one read at `regM+regN`, `regM+constField` and `regM+regN+constField` respectively, each taken modulo 2^32.
- R6: A fetch with `addrMode`=7, or any request with `opKind`=3, completes with `errFlag`=1 in its `done` cycle and makes no memory access. All other requests end with `errFlag`=0.
- R7: `opKind`=1 (push) ignores `addrMode` and writes `pushData` at `stackPtr-4`. In its `done` cycle it raises `spWe` with `spOut`=`stackPtr-4`. A fetch never raises `spWe`.
- R8: `opKind`=2 (pop) reads at `stackPtr` and returns that word on `operand`. In its `done` cycle it raises `spWe` with `spOut`=`stackPtr+4`. A push followed by a pop returns the pushed value and restores the pointer.
- R9: `reqReady` is low from the cycle after acceptance until the request completes. A memory request keeps its address and strobe until `memReady`. `memRd` and `memWr` are never high together. `done` lasts exactly one cycle.
- R10: After reset `reqReady`=1, and `done`, `memRd`, `memWr` and `spWe` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request strobe, taken when reqReady is high |
| reqReady | output | 1 | Unit idle and able to accept a request |
| opKind | input | 2 | 0 fetch, 1 push, 2 pop, 3 invalid |
| addrMode | input | 3 | Addressing mode code for fetches |
| constField | input | 32 | Constant field of the specifier |
| regM | input | 32 | Base register value |
| regN | input | 32 | Index / indirect register value |
| stackPtr | input | 32 | Current stack pointer value |
| pushData | input | 32 | Value stored by a push |
| memRd | output | 1 | Memory read request |
| memWr | output | 1 | Memory write request |
| memAddr | output | 32 | Byte address of the memory request |
| memWdata | output | 32 | Write data |
| memRdata | input | 32 | Read data, valid with memReady |
| memReady | input | 1 | Memory completes the current request |
| done | output | 1 | One-cycle completion pulse |
| operand | output | 32 | Fetched operand, valid with done |
| errFlag | output | 1 | Request rejected, valid with done |
| spOut | output | 32 | Updated stack pointer |
| spWe | output | 1 | Stack pointer write strobe |

## Verification
If the controller's two-step flag or its latched kind is corrupted, the effect shows at the ports within the same request. An indirect fetch makes the wrong number of memory references, a push raises `memRd` instead of `memWr`, or `spWe` is missing from the `done` cycle. A wrong effective-address register appears on `memAddr` on the first cycle of the access, and a lost pointer capture appears on the second access of an indirect fetch. Damage to stored stack data appears only when the matching pop returns, so push/pop pairs are checked back to back.

// File: rtl/opf_pkg.sv
package opf_pkg;
  typedef enum logic [2:0] {
    MODE_IMM  = 3'd0,
    MODE_DIR  = 3'd1,
    MODE_IND  = 3'd2,
    MODE_RIND = 3'd3,
    MODE_IDX  = 3'd4,
    MODE_BASE = 3'd5,
    MODE_BIDX = 3'd6,
    MODE_RSVD = 3'd7
  } addrMode_e;

  typedef enum logic [1:0] {
    OP_FETCH = 2'd0,
    OP_PUSH  = 2'd1,
    OP_POP   = 2'd2,
    OP_BAD   = 2'd3
  } opKind_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ1 = 2'd1,
    ST_READ2 = 2'd2,
    ST_DONE  = 2'd3
  } fsmState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic acceptReq;
    logic takeConst;
    logic takePointer;
    logic takeData;
    logic flagError;
    logic commitSp;
  } ctrlStrobe_t;
endpackage

// File: rtl/opf_addr_gen.sv
module opf_addr_gen
  import opf_pkg::*;
#(
  parameter int WIDTH   = 32,
  parameter int SP_STEP = 4
) (
  input  addrMode_e          mode,
  input  opKind_e            kind,
  input  logic [WIDTH-1:0]   constField,
  input  logic [WIDTH-1:0]   regM,
  input  logic [WIDTH-1:0]   regN,
  input  logic [WIDTH-1:0]   stackPtr,
  output logic [WIDTH-1:0]   effAddr,
  output logic [WIDTH-1:0]   spNext
);
  localparam logic [WIDTH-1:0] STEP = WIDTH'(SP_STEP);

  always_comb begin
    effAddr = constField;
    spNext  = stackPtr;
    unique case (kind)
      OP_PUSH: begin
        effAddr = stackPtr - STEP;
        spNext  = stackPtr - STEP;
      end
      OP_POP: begin
        effAddr = stackPtr;
        spNext  = stackPtr + STEP;
      end
      default: begin
        case (mode)
          MODE_RIND: effAddr = regN;
          MODE_IDX:  effAddr = regM + regN;
          MODE_BASE: effAddr = regM + constField;
          MODE_BIDX: effAddr = regM + regN + constField;
          default:   effAddr = constField;
        endcase
      end
    endcase
  end
endmodule

// File: rtl/opf_ctrl.sv
module opf_ctrl
  import opf_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  addrMode_e   mode,
  input  opKind_e     kind,
  input  logic        memReady,
  output ctrlStrobe_t strobe,
  output logic        memRd,
  output logic        memWr,
  output logic        reqReady,
  output logic        done
);
  fsmState_e state, stateNext;
  logic twoStep, writeOp, stackOp;
  logic twoStepNext, writeOpNext, stackOpNext;

  always_comb begin
    stateNext   = state;
    twoStepNext = twoStep;
    writeOpNext = writeOp;
    stackOpNext = stackOp;
    strobe      = '0;
    memRd       = 1'b0;
    memWr       = 1'b0;
    reqReady    = 1'b0;
    done        = 1'b0;
    unique case (state)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          strobe.acceptReq = 1'b1;
          twoStepNext = (kind == OP_FETCH) && (mode == MODE_IND);
          writeOpNext = (kind == OP_PUSH);
          stackOpNext = (kind == OP_PUSH) || (kind == OP_POP);
          if ((kind == OP_BAD) || ((kind == OP_FETCH) && (mode == MODE_RSVD))) begin
            strobe.flagError = 1'b1;
            stackOpNext = 1'b0;
            stateNext = ST_DONE;
          end else if ((kind == OP_FETCH) && (mode == MODE_IMM)) begin
            strobe.takeConst = 1'b1;
            stateNext = ST_DONE;
          end else begin
            stateNext = ST_READ1;
          end
        end
      end
      ST_READ1: begin
        memRd = !writeOp;
        memWr = writeOp;
        if (memReady) begin
          if (twoStep) begin
            strobe.takePointer = 1'b1;
            stateNext = ST_READ2;
          end else begin
            strobe.takeData = !writeOp;
            stateNext = ST_DONE;
          end
        end
      end
      ST_READ2: begin
        memRd = 1'b1;
        if (memReady) begin
          strobe.takeData = 1'b1;
          stateNext = ST_DONE;
        end
      end
      default: begin
        done = 1'b1;
        strobe.commitSp = stackOp;
        stateNext = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      twoStep <= 1'b0;
      writeOp <= 1'b0;
      stackOp <= 1'b0;
    end else begin
      state   <= stateNext;
      twoStep <= twoStepNext;
      writeOp <= writeOpNext;
      stackOp <= stackOpNext;
    end
  end
endmodule

// File: rtl/opf_datapath.sv
module opf_datapath
  import opf_pkg::*;
#(
  parameter int WIDTH   = 32,
  parameter int SP_STEP = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      strobe,
  input  addrMode_e        mode,
  input  opKind_e          kind,
  input  logic [WIDTH-1:0] constField,
  input  logic [WIDTH-1:0] regM,
  input  logic [WIDTH-1:0] regN,
  input  logic [WIDTH-1:0] stackPtr,
  input  logic [WIDTH-1:0] pushData,
  input  logic [WIDTH-1:0] memRdata,
  output logic [WIDTH-1:0] memAddr,
  output logic [WIDTH-1:0] memWdata,
  output logic [WIDTH-1:0] operand,
  output logic             errFlag,
  output logic [WIDTH-1:0] spOut,
  output logic             spWe
);
  logic [WIDTH-1:0] effAddr, spNext;
  logic [WIDTH-1:0] eaReg, operandReg, spReg, wdataReg;
  logic             errReg;

  opf_addr_gen #(.WIDTH(WIDTH), .SP_STEP(SP_STEP)) u_addrGen (
    .mode      (mode),
    .kind      (kind),
    .constField(constField),
    .regM      (regM),
    .regN      (regN),
    .stackPtr  (stackPtr),
    .effAddr   (effAddr),
    .spNext    (spNext)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      eaReg      <= '0;
      operandReg <= '0;
      spReg      <= '0;
      wdataReg   <= '0;
      errReg     <= 1'b0;
    end else begin
      if (strobe.acceptReq) begin
        eaReg    <= effAddr;
        spReg    <= spNext;
        wdataReg <= pushData;
        errReg   <= strobe.flagError;
      end
      if (strobe.takeConst)   operandReg <= constField;
      if (strobe.takePointer) eaReg      <= memRdata;
      if (strobe.takeData)    operandReg <= memRdata;
    end
  end

  assign memAddr  = eaReg;
  assign memWdata = wdataReg;
  assign operand  = operandReg;
  assign errFlag  = errReg;
  assign spOut    = spReg;
  assign spWe     = strobe.commitSp;
endmodule

// File: rtl/operand_fetch_unit.sv
module operand_fetch_unit
  import opf_pkg::*;
#(
  parameter int WIDTH   = 32,
  parameter int SP_STEP = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic [1:0]       opKind,
  input  logic [2:0]       addrMode,
  input  logic [WIDTH-1:0] constField,
  input  logic [WIDTH-1:0] regM,
  input  logic [WIDTH-1:0] regN,
  input  logic [WIDTH-1:0] stackPtr,
  input  logic [WIDTH-1:0] pushData,
  output logic             memRd,
  output logic             memWr,
  output logic [WIDTH-1:0] memAddr,
  output logic [WIDTH-1:0] memWdata,
  input  logic [WIDTH-1:0] memRdata,
  input  logic             memReady,
  output logic             done,
  output logic [WIDTH-1:0] operand,
  output logic             errFlag,
  output logic [WIDTH-1:0] spOut,
  output logic             spWe
);
  ctrlStrobe_t strobe;
  addrMode_e   modeIn;
  opKind_e     kindIn;

  assign modeIn = addrMode_e'(addrMode);
  assign kindIn = opKind_e'(opKind);

  opf_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .mode    (modeIn),
    .kind    (kindIn),
    .memReady(memReady),
    .strobe  (strobe),
    .memRd   (memRd),
    .memWr   (memWr),
    .reqReady(reqReady),
    .done    (done)
  );

  opf_datapath #(.WIDTH(WIDTH), .SP_STEP(SP_STEP)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .mode      (modeIn),
    .kind      (kindIn),
    .constField(constField),
    .regM      (regM),
    .regN      (regN),
    .stackPtr  (stackPtr),
    .pushData  (pushData),
    .memRdata  (memRdata),
    .memAddr   (memAddr),
    .memWdata  (memWdata),
    .operand   (operand),
    .errFlag   (errFlag),
    .spOut     (spOut),
    .spWe      (spWe)
  );
endmodule

// File: rtl/opf_checker.sv
module opf_checker #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqReady,
  input logic             done,
  input logic             errFlag,
  input logic             memRd,
  input logic             memWr,
  input logic             memReady,
  input logic [WIDTH-1:0] memAddr,
  input logic             spWe
);
  assert_rw_exclusive_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(memRd && memWr));

  assert_addr_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (memRd || memWr) && !memReady |=> $stable(memAddr) && (memRd || memWr));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !(memRd || memWr) && !done);

  assert_sp_with_done_R7: assert property (@(posedge clk) disable iff (!rstN)
    spWe |-> done);

  assert_err_no_access_R6: assert property (@(posedge clk) disable iff (!rstN)
    done && errFlag |-> $past(reqReady) && !spWe);
endmodule

bind operand_fetch_unit opf_checker #(.WIDTH(WIDTH)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .reqReady(reqReady),
  .done    (done),
  .errFlag (errFlag),
  .memRd   (memRd),
  .memWr   (memWr),
  .memReady(memReady),
  .memAddr (memAddr),
  .spWe    (spWe)
);

// File: tb/operand_fetch_unit_tb.sv
module operand_fetch_unit_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [1:0]  opKind = '0;
  logic [2:0]  addrMode = '0;
  logic [31:0] constField = '0, regM = '0, regN = '0, stackPtr = '0, pushData = '0;
  logic        memRd, memWr;
  logic [31:0] memAddr, memWdata;
  logic [31:0] memRdata = '0;
  logic        memReady = 1'b0;
  logic        done, errFlag, spWe;
  logic [31:0] operand, spOut;

  int tests = 0, fails = 0;
  int waitN = 0, waitCnt = 0, accCnt = 0;
  logic [31:0] addrLog [2];
  logic [31:0] mem [256];
  logic [31:0] gotOp, gotSp;
  logic        gotErr, gotSpWe;

  always #10 clk = ~clk;

  operand_fetch_unit u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .opKind(opKind), .addrMode(addrMode), .constField(constField),
    .regM(regM), .regN(regN), .stackPtr(stackPtr), .pushData(pushData),
    .memRd(memRd), .memWr(memWr), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .memReady(memReady), .done(done), .operand(operand),
    .errFlag(errFlag), .spOut(spOut), .spWe(spWe)
  );

  // memory model: word array indexed by address bits [9:2], variable latency
  always @(negedge clk) begin
    if (!rstN) begin
      memReady = 1'b0;
      waitCnt = 0;
    end else if (memReady) begin
      memReady = 1'b0;
      waitCnt = 0;
    end else if (memRd || memWr) begin
      if (waitCnt >= waitN) begin
        memReady = 1'b1;
        if (memWr) mem[memAddr[9:2]] = memWdata;
        else memRdata = mem[memAddr[9:2]];
        if (accCnt < 2) addrLog[accCnt] = memAddr;
        accCnt++;
        waitCnt = 0;
      end else begin
        waitCnt++;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doReq(input logic [1:0] k, input logic [2:0] md, input logic [31:0] kf,
                       input logic [31:0] m, input logic [31:0] n, input logic [31:0] sp,
                       input logic [31:0] pd);
    int guard;
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    accCnt = 0;
    opKind = k; addrMode = md; constField = kf; regM = m; regN = n;
    stackPtr = sp; pushData = pd; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    if (!done) chk("R9 busy reqReady", 32'(reqReady), 32'd0);
    guard = 0;
    while (!done && guard < 1000) begin
      @(negedge clk);
      guard++;
    end
    chk("R9 done seen", 32'(done), 32'd1);
    gotOp = operand; gotErr = errFlag; gotSp = spOut; gotSpWe = spWe;
    @(negedge clk);
    chk("R9 done one cycle", 32'(done), 32'd0);
  endtask

  function automatic logic [31:0] expEa(input logic [2:0] md, input logic [31:0] kf,
                                        input logic [31:0] m, input logic [31:0] n);
    case (md)
      3'd3: return n;
      3'd4: return m + n;
      3'd5: return m + kf;
      3'd6: return m + n + kf;
      default: return kf;
    endcase
  endfunction

  initial begin
    int cyc = 0;
    while (cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    fails++;
    $display("FAIL watchdog actual=%0d expected=<150000", cyc);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] pk [4], pm [4], pn [4];
    pk[0] = 32'h40;       pm[0] = 32'h100;      pn[0] = 32'h20;
    pk[1] = 32'h3FC;      pm[1] = 32'h0;        pn[1] = 32'h3F0;
    pk[2] = 32'h10;       pm[2] = 32'hFFFFFFF0; pn[2] = 32'h8;
    pk[3] = 32'hFFFFFFFC; pm[3] = 32'h200;      pn[3] = 32'hFFFFFF00;
    for (int i = 0; i < 256; i++) mem[i] = 32'h9E3779B9 * (i + 1);

    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 reqReady", 32'(reqReady), 32'd1);
    chk("R10 done", 32'(done), 32'd0);
    chk("R10 memRd/memWr", {30'd0, memRd, memWr}, 32'd0);
    chk("R10 spWe", 32'(spWe), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R10 idle after release", 32'(reqReady), 32'd1);

    // fetch sweep: every mode code against every operand pattern
    for (int p = 0; p < 4; p++) begin
      for (int md = 0; md < 8; md++) begin
        logic [31:0] ea, ptr;
        waitN = (p + md) % 3;
        doReq(2'd0, 3'(md), pk[p], pm[p], pn[p], 32'h0, 32'h0);
        ea = expEa(3'(md), pk[p], pm[p], pn[p]);
        chk("R7 fetch no spWe", 32'(gotSpWe), 32'd0);
        if (md == 0) begin
          chk("R1 imm operand", gotOp, pk[p]);
          chk("R1 imm no access", 32'(accCnt), 32'd0);
          chk("R6 imm err clear", 32'(gotErr), 32'd0);
        end else if (md == 7) begin
          chk("R6 reserved err", 32'(gotErr), 32'd1);
          chk("R6 reserved no access", 32'(accCnt), 32'd0);
        end else if (md == 2) begin
          ptr = mem[pk[p][9:2]];
          chk("R3 two accesses", 32'(accCnt), 32'd2);
          chk("R3 first addr", addrLog[0], pk[p]);
          chk("R3 pointer addr", addrLog[1], ptr);
          chk("R3 operand", gotOp, mem[ptr[9:2]]);
          chk("R6 ind err clear", 32'(gotErr), 32'd0);
        end else begin
          chk(md == 1 ? "R2 one access" : (md == 3 ? "R4 one access" : "R5 one access"),
              32'(accCnt), 32'd1);
          chk(md == 1 ? "R2 addr" : (md == 3 ? "R4 addr" : "R5 addr"), addrLog[0], ea);
          chk(md == 1 ? "R2 operand" : (md == 3 ? "R4 operand" : "R5 operand"),
              gotOp, mem[ea[9:2]]);
          chk("R6 err clear", 32'(gotErr), 32'd0);
        end
      end
    end

    // invalid kind
    waitN = 0;
    doReq(2'd3, 3'd1, 32'h40, 32'h0, 32'h0, 32'h100, 32'h0);
    chk("R6 bad kind err", 32'(gotErr), 32'd1);
    chk("R6 bad kind no access", 32'(accCnt), 32'd0);
    chk("R6 bad kind no spWe", 32'(gotSpWe), 32'd0);

    // push then pop pairs, including pointer wrap at zero
    for (int s = 0; s < 3; s++) begin
      logic [31:0] sp, val;
      sp  = (s == 0) ? 32'h100 : ((s == 1) ? 32'h0 : 32'h3F0);
      val = 32'hC0DE0000 + 32'(s * 17);
      waitN = s;
      doReq(2'd1, 3'd7, 32'h0, 32'h0, 32'h0, sp, val);
      chk("R7 push one access", 32'(accCnt), 32'd1);
      chk("R7 push addr", addrLog[0], sp - 32'd4);
      chk("R7 push stored", mem[(sp - 32'd4) >> 2 & 32'hFF], val);
      chk("R7 push spWe", 32'(gotSpWe), 32'd1);
      chk("R7 push spOut", gotSp, sp - 32'd4);
      chk("R7 push mode ignored", 32'(gotErr), 32'd0);
      doReq(2'd2, 3'd0, 32'h0, 32'h0, 32'h0, gotSp, 32'h0);
      chk("R8 pop addr", addrLog[0], sp - 32'd4);
      chk("R8 pop operand", gotOp, val);
      chk("R8 pop spWe", 32'(gotSpWe), 32'd1);
      chk("R8 pop restores sp", gotSp, sp);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule